// File: doc/BRIEF.md
# Control and Status Register Access Unit

This unit keeps a small bank of control and status registers beside an instruction pipeline and answers one access per request. Each request carries a 12-bit register address, a two-bit operation code, a data operand and the privilege level the hart currently runs at. The unit checks the access, returns the register's old value and, when the access is legal and writes, stores the new value at the next rising clock edge.

Address bits decide the checks. Bits [9:8] give the lowest privilege level that may see the register. Bits [11:10] equal to 2'b11 mark a read-only register. The unit flags an illegal instruction for any of these: an address it does not implement, a reserved operation code, too little privilege, or a write to a read-only register. Inside the writable registers each field follows its own rule. Some fields keep their stored value on every write. Some accept only a defined set of codes. Some store anything but read back only legal codes. Some are absent: they read as zero and ignore writes.

The implemented registers are: a machine configuration register at 0x300, a machine vector-mode register at 0x305, a supervisor scratch register at 0x140, a user scratch register at 0x040 and a machine identity register at 0xF11.

Top module: `csr_policy_unit`

## Requirements
- R1: Privilege codes are 00 user, 01 supervisor and 11 machine. An access whose `req_priv` is numerically lower than `req_addr[9:8]` raises `rsp_illegal`.
- R2: An illegal access changes no register and returns `rsp_rdata` of zero.
- R3: Addresses with bits [11:10] = 11 are read-only. Operation 01, or operation 10 or 11 with a nonzero operand, raises `rsp_illegal` there. Operation 10 or 11 with a zero operand is legal and returns the register value.
- R4: An address outside the five implemented ones, or operation code 00, raises `rsp_illegal`.
- R5: Operation 01 stores the operand. Operation 10 stores the read value OR the operand. Operation 11 stores the read value AND the inverted operand. `rsp_rdata` shows the old value in the request cycle, and the new value is readable from the following cycle.
- R6: Bits [7:2] of the configuration register (0x300) keep their stored value on every write and always read as zero.
- R7: Bits [1:0] of the configuration register accept only 00, 01 and 11. Writing 10 leaves those two bits unchanged, while the rest of the same write still takes effect.
- R8: Bits [1:0] of the vector-mode register (0x305) store any value. A stored 10 or 11 reads back as the legal code 00.
- R9: The upper half of the user scratch register (0x040) always reads as zero and ignores writes. The lower half is read-write.
- R10: The identity register (0xF11) reads as the `ID_VALUE` parameter, 32'h5A17_0001 by default.
- R11: After reset the configuration register reads 32'h0000_0003 and the vector-mode and scratch registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 12 | Register address |
| req_op | input | 2 | 00 reserved, 01 write, 10 set bits, 11 clear bits |
| req_operand | input | XLEN | Write value or bit mask |
| req_priv | input | 2 | Current privilege level |
| rsp_rdata | output | XLEN | Old register value (read view) |
| rsp_illegal | output | 1 | Illegal-instruction flag |

## Verification
`rsp_rdata` and `rsp_illegal` are combinational and must be correct in the same cycle as the request strobe. A register update becomes visible one cycle after the request, on the following access. The driver applies each request just after a falling edge and queues its expected response. The monitor takes that entry two nanoseconds later, before the next rising edge, so every comparison falls inside the request cycle. Each later read then confirms the state stored at that edge, including after illegal accesses that must leave the state untouched.

// File: rtl/csr_pkg.sv
package csr_pkg;

   typedef enum logic [1:0] {
      OP_RSVD  = 2'b00,
      OP_WRITE = 2'b01,
      OP_SET   = 2'b10,
      OP_CLEAR = 2'b11
   } csr_op_e;

   localparam int unsigned NUM_CSR  = 5;
   localparam int unsigned IDX_CFG  = 0;
   localparam int unsigned IDX_VEC  = 1;
   localparam int unsigned IDX_SSCR = 2;
   localparam int unsigned IDX_USCR = 3;
   localparam int unsigned IDX_ID   = 4;

   localparam logic [11:0] ADDR_CFG  = 12'h300;
   localparam logic [11:0] ADDR_VEC  = 12'h305;
   localparam logic [11:0] ADDR_SSCR = 12'h140;
   localparam logic [11:0] ADDR_USCR = 12'h040;
   localparam logic [11:0] ADDR_ID   = 12'hF11;

   function automatic logic [11:0] csr_addr(input int unsigned idx);
      case (idx)
         IDX_CFG:  return ADDR_CFG;
         IDX_VEC:  return ADDR_VEC;
         IDX_SSCR: return ADDR_SSCR;
         IDX_USCR: return ADDR_USCR;
         default:  return ADDR_ID;
      endcase
   endfunction

endpackage

// File: rtl/csr_access_check.sv
module csr_access_check
   import csr_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic                req_valid,
   input  logic [11:0]         req_addr,
   input  logic [1:0]          req_op,
   input  logic [XLEN-1:0]     req_operand,
   input  logic [1:0]          req_priv,
   output logic [NUM_CSR-1:0]  hit,
   output logic [NUM_CSR-1:0]  wr_sel,
   output logic                illegal
);

   logic any_hit;
   logic wants_write;
   logic priv_ok;
   logic read_only;
   logic commit;

   for (genvar i = 0; i < NUM_CSR; i++) begin : g_hit
      assign hit[i] = (req_addr == csr_addr(i));
   end

   assign any_hit     = |hit;
   assign wants_write = (req_op == OP_WRITE) ||
                        (((req_op == OP_SET) || (req_op == OP_CLEAR)) && (req_operand != '0));
   assign priv_ok     = (req_priv >= req_addr[9:8]);
   assign read_only   = (req_addr[11:10] == 2'b11);

   assign illegal = req_valid && (!any_hit || (req_op == OP_RSVD) || !priv_ok ||
                                  (read_only && wants_write));
   assign commit  = req_valid && !illegal && wants_write;
   assign wr_sel  = hit & {NUM_CSR{commit}};

endmodule

// File: rtl/csr_update_calc.sv
module csr_update_calc
   import csr_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [1:0]      op,
   input  logic [XLEN-1:0] operand,
   input  logic [XLEN-1:0] old_view,
   output logic [XLEN-1:0] new_val
);

   always_comb begin
      case (op)
         OP_WRITE: new_val = operand;
         OP_SET:   new_val = old_view | operand;
         OP_CLEAR: new_val = old_view & ~operand;
         default:  new_val = old_view;
      endcase
   end

endmodule

// File: rtl/csr_bank.sv
module csr_bank
   import csr_pkg::*;
#(
   parameter int unsigned  XLEN           = 32,
   parameter logic [31:0]  ID_VALUE       = 32'h5A17_0001,
   parameter logic [1:0]   WARL_CODE      = 2'b00,
   parameter logic [1:0]   CFG_RESET_MODE = 2'b11
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CSR-1:0]      wr_sel,
   input  logic [XLEN-1:0]         wr_val,
   output logic [NUM_CSR*XLEN-1:0] view_flat
);

   localparam int unsigned RSV_LO = 2;
   localparam int unsigned RSV_HI = 7;
   localparam int unsigned RSV_W  = RSV_HI - RSV_LO + 1;
   localparam int unsigned HALF   = XLEN / 2;

   for (genvar i = 0; i < NUM_CSR; i++) begin : g_csr
      if (i == IDX_ID) begin : g_const
         logic unused_wr;
         assign unused_wr = wr_sel[i];
         assign view_flat[i*XLEN +: XLEN] = XLEN'(ID_VALUE);
      end else begin : g_rw
         localparam logic [XLEN-1:0] RST_VAL =
            (i == IDX_CFG) ? XLEN'(CFG_RESET_MODE) : '0;
         logic [XLEN-1:0] q;
         logic [XLEN-1:0] d;
         logic [XLEN-1:0] view;

         if (i == IDX_CFG) begin : g_cfg
            always_comb begin
               d = wr_val;
               d[RSV_HI:RSV_LO] = q[RSV_HI:RSV_LO];
               if (wr_val[1:0] == 2'b10) d[1:0] = q[1:0];
            end
            assign view = {q[XLEN-1:RSV_HI+1], {RSV_W{1'b0}}, q[1:0]};
         end else if (i == IDX_VEC) begin : g_vec
            assign d    = wr_val;
            assign view = {q[XLEN-1:2], (q[1:0] > 2'b01) ? WARL_CODE : q[1:0]};
         end else if (i == IDX_USCR) begin : g_uscr
            assign d    = {{(XLEN-HALF){1'b0}}, wr_val[HALF-1:0]};
            assign view = q;
         end else begin : g_plain
            assign d    = wr_val;
            assign view = q;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q <= RST_VAL;
            else if (wr_sel[i]) q <= d;
         end

         assign view_flat[i*XLEN +: XLEN] = view;
      end
   end

endmodule

// File: rtl/csr_policy_unit.sv
module csr_policy_unit
   import csr_pkg::*;
#(
   parameter int unsigned XLEN           = 32,
   parameter logic [31:0] ID_VALUE       = 32'h5A17_0001,
   parameter logic [1:0]  WARL_CODE      = 2'b00,
   parameter logic [1:0]  CFG_RESET_MODE = 2'b11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [11:0]     req_addr,
   input  logic [1:0]      req_op,
   input  logic [XLEN-1:0] req_operand,
   input  logic [1:0]      req_priv,
   output logic [XLEN-1:0] rsp_rdata,
   output logic            rsp_illegal
);

   if (XLEN < 16 || XLEN > 32 || (XLEN % 2) != 0) begin : g_bad_xlen
      $error("csr_policy_unit: XLEN must be even and within 16..32");
   end
   if (WARL_CODE > 2'b01) begin : g_bad_warl
      $error("csr_policy_unit: WARL_CODE must itself be a legal code");
   end
   if (CFG_RESET_MODE == 2'b10) begin : g_bad_mode
      $error("csr_policy_unit: CFG_RESET_MODE must be a legal mode code");
   end

   logic [NUM_CSR-1:0]      hit;
   logic [NUM_CSR-1:0]      wr_sel;
   logic                    illegal;
   logic [NUM_CSR*XLEN-1:0] view_flat;
   logic [XLEN-1:0]         rd_view;
   logic [XLEN-1:0]         new_val;

   csr_access_check #(.XLEN(XLEN)) u_check (
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .req_op      (req_op),
      .req_operand (req_operand),
      .req_priv    (req_priv),
      .hit         (hit),
      .wr_sel      (wr_sel),
      .illegal     (illegal)
   );

   always_comb begin
      rd_view = '0;
      for (int i = 0; i < NUM_CSR; i++) begin
         if (hit[i]) rd_view = rd_view | view_flat[i*XLEN +: XLEN];
      end
   end

   csr_update_calc #(.XLEN(XLEN)) u_calc (
      .op       (req_op),
      .operand  (req_operand),
      .old_view (rd_view),
      .new_val  (new_val)
   );

   csr_bank #(
      .XLEN           (XLEN),
      .ID_VALUE       (ID_VALUE),
      .WARL_CODE      (WARL_CODE),
      .CFG_RESET_MODE (CFG_RESET_MODE)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (wr_sel),
      .wr_val    (new_val),
      .view_flat (view_flat)
   );

   assign rsp_illegal = illegal;
   assign rsp_rdata   = (req_valid && !illegal) ? rd_view : '0;

endmodule

// File: rtl/csr_policy_chk.sv
module csr_policy_chk
   import csr_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic [11:0]             req_addr,
   input logic [1:0]              req_op,
   input logic [XLEN-1:0]         req_operand,
   input logic [1:0]              req_priv,
   input logic [XLEN-1:0]         rsp_rdata,
   input logic                    rsp_illegal,
   input logic [NUM_CSR*XLEN-1:0] view_flat
);

   // R1
   priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_priv < req_addr[9:8])) |-> rsp_illegal);

   // R2
   illegal_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && rsp_illegal) |=> $stable(view_flat));

   // R2
   illegal_zero_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_illegal |-> (rsp_rdata == '0));

   // R3
   ro_write_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_addr[11:10] == 2'b11) &&
       ((req_op == OP_WRITE) || (req_operand != '0))) |-> rsp_illegal);

   // R4
   rsvd_op_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == OP_RSVD)) |-> rsp_illegal);

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(view_flat));

   // R6
   reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_illegal && (req_addr == ADDR_CFG)) |-> (rsp_rdata[7:2] == 6'd0));

   // R8
   warl_legal_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_illegal && (req_addr == ADDR_VEC)) |-> (rsp_rdata[1:0] <= 2'b01));

   // R9
   absent_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_illegal && (req_addr == ADDR_USCR)) |->
      (rsp_rdata[XLEN-1:XLEN/2] == '0));

endmodule

bind csr_policy_unit csr_policy_chk #(.XLEN(XLEN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_addr    (req_addr),
   .req_op      (req_op),
   .req_operand (req_operand),
   .req_priv    (req_priv),
   .rsp_rdata   (rsp_rdata),
   .rsp_illegal (rsp_illegal),
   .view_flat   (view_flat)
);

// File: tb/sim_csr_policy_unit.sv
`timescale 1ns/100ps
module sim_csr_policy_unit;

   localparam logic [1:0]  OPW = 2'b01, OPS = 2'b10, OPC = 2'b11, OPR = 2'b00;
   localparam logic [1:0]  PU = 2'b00, PS = 2'b01, PM = 2'b11;
   localparam logic [31:0] IDV = 32'h5A17_0001;
   localparam logic [11:0] A_CFG = 12'h300, A_VEC = 12'h305, A_SSCR = 12'h140,
                           A_USCR = 12'h040, A_ID = 12'hF11, A_NONE = 12'h341;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [11:0] req_addr = '0;
   logic [1:0]  req_op = '0;
   logic [31:0] req_operand = '0;
   logic [1:0]  req_priv = '0;
   logic [31:0] rsp_rdata;
   logic        rsp_illegal;

   int n_tests = 0;
   int n_fail  = 0;

   logic [31:0] exp_data_q[$];
   logic        exp_ill_q[$];
   string       exp_tag_q[$];

   always #2.5 clk = ~clk;

   csr_policy_unit u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .req_op      (req_op),
      .req_operand (req_operand),
      .req_priv    (req_priv),
      .rsp_rdata   (rsp_rdata),
      .rsp_illegal (rsp_illegal)
   );

   task automatic acc(input logic [11:0] a, input logic [1:0] op, input logic [31:0] d,
                      input logic [1:0] p, input logic [31:0] er, input logic ei,
                      input string tag);
      @(negedge clk);
      req_valid   = 1'b1;
      req_addr    = a;
      req_op      = op;
      req_operand = d;
      req_priv    = p;
      exp_data_q.push_back(er);
      exp_ill_q.push_back(ei);
      exp_tag_q.push_back(tag);
   endtask

   task automatic rd(input logic [11:0] a, input logic [1:0] p, input logic [31:0] er,
                     input string tag);
      acc(a, OPS, 32'h0, p, er, 1'b0, tag);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: compares each queued item inside its request cycle
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (exp_data_q.size() > 0) begin
            logic [31:0] ed;
            logic        ei;
            string       t;
            ed = exp_data_q.pop_front();
            ei = exp_ill_q.pop_front();
            t  = exp_tag_q.pop_front();
            n_tests++;
            if (rsp_rdata !== ed || rsp_illegal !== ei) begin
               n_fail++;
               $display("FAIL %s: rdata=%h illegal=%b expected rdata=%h illegal=%b",
                        t, rsp_rdata, rsp_illegal, ed, ei);
            end
         end
      end
   end

   initial begin
      #(5.0 * 20000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset values, R10 identity
      rd(A_CFG,  PM, 32'h0000_0003, "R11 cfg reset");
      rd(A_VEC,  PM, 32'h0,         "R11 vec reset");
      rd(A_SSCR, PS, 32'h0,         "R11 sscr reset");
      rd(A_USCR, PU, 32'h0,         "R11 uscr reset");
      rd(A_ID,   PM, IDV,           "R10 id value");

      // R5 write / set / clear
      acc(A_SSCR, OPW, 32'hDEAD_BEEF, PS, 32'h0, 1'b0, "R5 write old");
      rd(A_SSCR, PS, 32'hDEAD_BEEF, "R5 write new");
      acc(A_SSCR, OPS, 32'h0000_0F00, PS, 32'hDEAD_BEEF, 1'b0, "R5 set old");
      acc(A_SSCR, OPC, 32'hDEAD_0000, PS, 32'hDEAD_BFEF, 1'b0, "R5 clear old");
      rd(A_SSCR, PS, 32'h0000_BFEF, "R5 clear new");

      // R1 privilege, R2 no change on fault
      acc(A_SSCR, OPW, 32'h1, PU, 32'h0, 1'b1, "R1 user to supervisor reg");
      rd(A_SSCR, PS, 32'h0000_BFEF, "R2 state kept after priv fault");
      rd(A_SSCR, PM, 32'h0000_BFEF, "R1 machine sees supervisor reg");
      acc(A_CFG, OPS, 32'h0, PU, 32'h0, 1'b1, "R1 user to machine reg");
      acc(A_CFG, OPS, 32'h0, PS, 32'h0, 1'b1, "R1 supervisor to machine reg");
      acc(A_ID,  OPS, 32'h0, PS, 32'h0, 1'b1, "R1 supervisor to id");

      // R3 read-only
      acc(A_ID, OPW, 32'h0,  PM, 32'h0, 1'b1, "R3 write to read-only");
      acc(A_ID, OPS, 32'h10, PM, 32'h0, 1'b1, "R3 set nonzero to read-only");
      acc(A_ID, OPC, 32'h0,  PM, IDV,   1'b0, "R3 clear zero on read-only");
      rd(A_ID, PM, IDV, "R2 id unchanged");

      // R4 unimplemented address and reserved op
      acc(A_NONE, OPS, 32'h0, PM, 32'h0, 1'b1, "R4 unimplemented address");
      acc(A_SSCR, OPR, 32'hFFFF_FFFF, PM, 32'h0, 1'b1, "R4 reserved op");
      rd(A_SSCR, PS, 32'h0000_BFEF, "R2 state kept after reserved op");

      // R6 reserved-preserve bits
      acc(A_CFG, OPW, 32'hFFFF_FFFD, PM, 32'h0000_0003, 1'b0, "R6 write old");
      rd(A_CFG, PM, 32'hFFFF_FF01, "R6 reserved bits read zero");

      // R7 legal-only mode field
      acc(A_CFG, OPW, 32'h1234_5602, PM, 32'hFFFF_FF01, 1'b0, "R7 illegal mode write");
      rd(A_CFG, PM, 32'h1234_5601, "R7 mode kept, rest written");
      acc(A_CFG, OPC, 32'h1, PM, 32'h1234_5601, 1'b0, "R7 clear to 00");
      rd(A_CFG, PM, 32'h1234_5600, "R7 mode 00 accepted");
      acc(A_CFG, OPS, 32'h3, PM, 32'h1234_5600, 1'b0, "R7 set to 11");
      acc(A_CFG, OPC, 32'h1, PM, 32'h1234_5603, 1'b0, "R7 clear to 10");
      rd(A_CFG, PM, 32'h1234_5603, "R7 mode 10 rejected");

      // R8 write-any-read-legal field
      acc(A_VEC, OPW, 32'hABCD_0002, PM, 32'h0, 1'b0, "R8 write 10");
      rd(A_VEC, PM, 32'hABCD_0000, "R8 10 reads 00");
      acc(A_VEC, OPW, 32'h3, PM, 32'hABCD_0000, 1'b0, "R8 write 11");
      rd(A_VEC, PM, 32'h0, "R8 11 reads 00");
      acc(A_VEC, OPW, 32'h1, PM, 32'h0, 1'b0, "R8 write 01");
      rd(A_VEC, PM, 32'h1, "R8 01 reads 01");
      acc(A_VEC, OPS, 32'h2, PM, 32'h1, 1'b0, "R8 set to 11");
      rd(A_VEC, PM, 32'h0, "R8 set result reads 00");

      // R9 absent upper half
      acc(A_USCR, OPW, 32'hFFFF_1234, PU, 32'h0, 1'b0, "R9 write");
      rd(A_USCR, PU, 32'h0000_1234, "R9 upper half zero");
      acc(A_USCR, OPS, 32'hFFFF_0000, PU, 32'h0000_1234, 1'b0, "R9 set upper");
      rd(A_USCR, PU, 32'h0000_1234, "R9 upper set ignored");

      // R11 reset mid-run
      idle();
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(A_CFG,  PM, 32'h0000_0003, "R11 cfg after reset");
      rd(A_SSCR, PS, 32'h0,         "R11 sscr after reset");
      rd(A_VEC,  PM, 32'h0,         "R11 vec after reset");

      idle();
      repeat (3) @(negedge clk);
      if (exp_data_q.size() != 0) begin
         n_fail++;
         $display("FAIL queue: %0d items left, expected 0", exp_data_q.size());
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule